// File: doc/BRIEF.md
# Clock Page Replacement Engine

This block holds three status bits for each physical page frame of a small memory: whether the frame is resident, whether it has been referenced since the hand last passed, and whether it has been modified since it was loaded. Read and write strobes from the host mark frames as referenced and modified. An access to a frame that is not resident is rejected and reported as a fault. Software signals the end of a page load with a completion strobe, and that strobe restores the frame's bits.

When the host asks for a frame to evict, a circular hand walks the frames one per clock. A referenced frame loses its referenced bit and gets a second chance. The first unreferenced frame becomes the victim. The engine returns the victim index, a flag that says whether the frame must be copied back before reuse, and a one-cycle completion pulse. It also marks the victim non-resident. The hand then rests on the frame after the victim, ready for the next request.

Top module: `clock_evict_engine`

## Requirements
- R1: During reset and after it, every frame is non-resident with all bits clear, the hand points at frame 0, and `acc_fault` and `evict_done` are low.
- R2: A read or write strobe to a resident frame sets its referenced bit, so the next sweep that reaches that frame skips it.
- R3: A write strobe to a resident frame sets its modified bit. When that frame is later chosen, `evict_dirty` is 1. A same-cycle write to the victim also counts.
- R4: A strobe to a non-resident frame changes no bit and raises `acc_fault` for exactly the following cycle. A strobe to a resident frame leaves `acc_fault` low.
- R5: A completion strobe on `fill_frame` makes the frame resident and referenced and clears its modified bit. It takes priority over every other update to that frame in the same cycle.
- R6: Once a request is accepted, the hand examines one frame per cycle in ascending index order, wrapping from the last frame to frame 0. It clears and passes each referenced frame and picks the first unreferenced one. `evict_done` is a single-cycle pulse.
- R7: If no strobes arrive during a sweep, `evict_done` appears at most NFRAMES+2 cycles after the cycle in which `evict_req` was sampled high.
- R8: The chosen frame becomes non-resident, so a later access to it faults until it is reloaded.
- R9: After a victim is chosen, the next sweep starts at the frame after the victim.
- R10: An access that lands on the frame under the hand in the same cycle keeps that frame's referenced bit set. The sweep then moves on past it.
- R11: `evict_req` is ignored while a sweep is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_valid | input | 1 | Access strobe |
| acc_write | input | 1 | Access is a write |
| acc_frame | input | IDX_W | Frame index of the access |
| acc_fault | output | 1 | Previous cycle's access hit a non-resident frame |
| fill_valid | input | 1 | Page load finished |
| fill_frame | input | IDX_W | Frame that was loaded |
| evict_req | input | 1 | Request a victim frame |
| evict_done | output | 1 | One-cycle pulse: victim chosen |
| evict_frame | output | IDX_W | Victim frame index |
| evict_dirty | output | 1 | Victim needs copying back |

## Verification
The bench drives the longest sweep, in which every frame is referenced and the hand must come back to its starting frame. A design that stops early or adds a step fails the victim and latency checks. It places an access on the frame under the hand in the exact cycle it is examined. A design that lets the sweep clear win would pick that frame instead of the next one. It reloads a modified frame and evicts it again to show the modified bit was dropped. It also probes an evicted frame for a fault, which catches a design that forgets to clear residency. A free-running random phase compares every output on every cycle with a behavioural model, including requests raised while a sweep is running.

// File: rtl/cea_pkg.sv
// Shared types for the clock eviction engine.
package cea_pkg;
    // Sweep controller state.
    typedef enum logic {
        HAND_IDLE  = 1'b0,
        HAND_SWEEP = 1'b1
    } hand_state_e;
endpackage

// File: rtl/cea_frame_bits.sv
// Per-frame status storage: resident, referenced and modified bits.
// Assumes at most one access, one fill and one sweep step per cycle.
// Priority per frame: fill, then access, then the sweep's clear and grant.
module cea_frame_bits #(
    parameter int NFRAMES = 16,
    parameter int IDX_W   = $clog2(NFRAMES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               acc_valid,
    input  logic               acc_write,
    input  logic [IDX_W-1:0]   acc_frame,
    input  logic               fill_valid,
    input  logic [IDX_W-1:0]   fill_frame,
    input  logic               step_clr,
    input  logic               step_grant,
    input  logic [IDX_W-1:0]   step_idx,
    output logic [NFRAMES-1:0] present_vec,
    output logic [NFRAMES-1:0] accessed_vec,
    output logic [NFRAMES-1:0] written_vec
);
    for (genvar g = 0; g < NFRAMES; g++) begin : g_frame
        logic p_q, a_q, w_q;
        logic hit_acc, hit_fill, hit_clr, hit_grant;

        // Decode which events target this frame.
        always_comb begin
            hit_acc   = acc_valid && (acc_frame == IDX_W'(g)) && p_q;
            hit_fill  = fill_valid && (fill_frame == IDX_W'(g));
            hit_clr   = step_clr && (step_idx == IDX_W'(g));
            hit_grant = step_grant && (step_idx == IDX_W'(g));
        end

        // Update the three status bits in priority order.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                p_q <= 1'b0;
                a_q <= 1'b0;
                w_q <= 1'b0;
            end else if (hit_fill) begin
                p_q <= 1'b1;
                a_q <= 1'b1;
                w_q <= 1'b0;
            end else begin
                if (hit_acc)
                    a_q <= 1'b1;
                else if (hit_clr)
                    a_q <= 1'b0;
                if (hit_acc && acc_write)
                    w_q <= 1'b1;
                if (hit_grant)
                    p_q <= 1'b0;
            end
        end

        assign present_vec[g]  = p_q;
        assign accessed_vec[g] = a_q;
        assign written_vec[g]  = w_q;
    end
endmodule

// File: rtl/cea_hand_sweep.sv
// Circular hand and sweep controller. It accepts a request when idle and
// examines one frame per cycle: it clears a referenced frame and moves on,
// or grants an unreferenced frame and returns to idle. It assumes the
// status bits reflect the previous clock edge.
module cea_hand_sweep
    import cea_pkg::*;
#(
    parameter int NFRAMES = 16,
    parameter int IDX_W   = $clog2(NFRAMES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               evict_req,
    input  logic [NFRAMES-1:0] present_vec,
    input  logic [NFRAMES-1:0] accessed_vec,
    input  logic [NFRAMES-1:0] written_vec,
    input  logic               acc_valid,
    input  logic               acc_write,
    input  logic [IDX_W-1:0]   acc_frame,
    output logic [IDX_W-1:0]   step_idx,
    output logic               step_clr,
    output logic               step_grant,
    output logic               busy,
    output logic               evict_done,
    output logic [IDX_W-1:0]   evict_frame,
    output logic               evict_dirty
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NFRAMES - 1);

    hand_state_e      state_q;
    logic [IDX_W-1:0] hand_q;
    logic [IDX_W-1:0] hand_next;
    logic             late_write;

    // Step decision for the frame under the hand.
    always_comb begin
        hand_next  = (hand_q == LAST_IDX) ? '0 : hand_q + 1'b1;
        step_clr   = (state_q == HAND_SWEEP) && accessed_vec[hand_q];
        step_grant = (state_q == HAND_SWEEP) && !accessed_vec[hand_q];
        late_write = acc_valid && acc_write && (acc_frame == hand_q)
                     && present_vec[hand_q];
    end

    // Hand position, sweep state and victim report registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= HAND_IDLE;
            hand_q      <= '0;
            evict_done  <= 1'b0;
            evict_frame <= '0;
            evict_dirty <= 1'b0;
        end else begin
            evict_done <= 1'b0;
            if (state_q == HAND_IDLE) begin
                if (evict_req)
                    state_q <= HAND_SWEEP;
            end else if (step_clr) begin
                hand_q <= hand_next;
            end else begin
                hand_q      <= hand_next;
                state_q     <= HAND_IDLE;
                evict_done  <= 1'b1;
                evict_frame <= hand_q;
                evict_dirty <= written_vec[hand_q] | late_write;
            end
        end
    end

    assign step_idx = hand_q;
    assign busy     = (state_q == HAND_SWEEP);
endmodule

// File: rtl/cea_fault_flag.sv
// Registers a one-cycle fault when an access targets a non-resident frame.
// It assumes present_vec is the registered residency state.
module cea_fault_flag #(
    parameter int NFRAMES = 16,
    parameter int IDX_W   = $clog2(NFRAMES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               acc_valid,
    input  logic [IDX_W-1:0]   acc_frame,
    input  logic [NFRAMES-1:0] present_vec,
    output logic               acc_fault
);
    // Flag the rejected access in the following cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)
            acc_fault <= 1'b0;
        else
            acc_fault <= acc_valid && !present_vec[acc_frame];
    end
endmodule

// File: rtl/clock_evict_engine.sv
// Top level of the clock eviction engine. It ties together the status bit
// storage, the sweep controller and the fault flag. All inputs are
// synchronous to clk, and the reset is synchronous and active low.
module clock_evict_engine #(
    parameter int NFRAMES = 16,
    parameter int IDX_W   = $clog2(NFRAMES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             acc_valid,
    input  logic             acc_write,
    input  logic [IDX_W-1:0] acc_frame,
    output logic             acc_fault,
    input  logic             fill_valid,
    input  logic [IDX_W-1:0] fill_frame,
    input  logic             evict_req,
    output logic             evict_done,
    output logic [IDX_W-1:0] evict_frame,
    output logic             evict_dirty
);
    logic [NFRAMES-1:0] present_vec;
    logic [NFRAMES-1:0] accessed_vec;
    logic [NFRAMES-1:0] written_vec;
    logic [IDX_W-1:0]   step_idx;
    logic               step_clr;
    logic               step_grant;
    logic               busy;

    cea_frame_bits #(.NFRAMES(NFRAMES), .IDX_W(IDX_W)) u_bits (
        .clk          (clk),
        .rst_n        (rst_n),
        .acc_valid    (acc_valid),
        .acc_write    (acc_write),
        .acc_frame    (acc_frame),
        .fill_valid   (fill_valid),
        .fill_frame   (fill_frame),
        .step_clr     (step_clr),
        .step_grant   (step_grant),
        .step_idx     (step_idx),
        .present_vec  (present_vec),
        .accessed_vec (accessed_vec),
        .written_vec  (written_vec)
    );

    cea_hand_sweep #(.NFRAMES(NFRAMES), .IDX_W(IDX_W)) u_sweep (
        .clk          (clk),
        .rst_n        (rst_n),
        .evict_req    (evict_req),
        .present_vec  (present_vec),
        .accessed_vec (accessed_vec),
        .written_vec  (written_vec),
        .acc_valid    (acc_valid),
        .acc_write    (acc_write),
        .acc_frame    (acc_frame),
        .step_idx     (step_idx),
        .step_clr     (step_clr),
        .step_grant   (step_grant),
        .busy         (busy),
        .evict_done   (evict_done),
        .evict_frame  (evict_frame),
        .evict_dirty  (evict_dirty)
    );

    cea_fault_flag #(.NFRAMES(NFRAMES), .IDX_W(IDX_W)) u_fault (
        .clk         (clk),
        .rst_n       (rst_n),
        .acc_valid   (acc_valid),
        .acc_frame   (acc_frame),
        .present_vec (present_vec),
        .acc_fault   (acc_fault)
    );
endmodule

// File: rtl/clock_evict_engine_chk.sv
// Assertion checker bound to the clock eviction engine. It watches the ports,
// the hand position and the sweep state over time.
module clock_evict_engine_chk #(
    parameter int NFRAMES = 16,
    parameter int IDX_W   = $clog2(NFRAMES)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             acc_valid,
    input logic             fill_valid,
    input logic             acc_fault,
    input logic             evict_done,
    input logic [IDX_W-1:0] evict_frame,
    input logic [IDX_W-1:0] step_idx,
    input logic             busy
);
    localparam int CNT_W = $clog2(NFRAMES + 4);

    logic [CNT_W-1:0] quiet_steps;
    logic [IDX_W-1:0] after_victim;

    // Count sweep cycles since the last strobe that could re-reference a frame.
    always_ff @(posedge clk) begin
        if (!rst_n || !busy || acc_valid || fill_valid)
            quiet_steps <= '0;
        else
            quiet_steps <= quiet_steps + 1'b1;
    end

    // Index of the frame that follows the reported victim.
    always_comb begin
        after_victim = (evict_frame == IDX_W'(NFRAMES - 1)) ? '0 : evict_frame + 1'b1;
    end

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> (!acc_fault && !evict_done));

    // R4
    fault_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_fault |-> $past(acc_valid));

    // R6
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evict_done |=> !evict_done);

    // R7
    sweep_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        quiet_steps <= CNT_W'(NFRAMES + 1));

    // R9
    hand_past_victim_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evict_done |-> (step_idx == after_victim));
endmodule

bind clock_evict_engine clock_evict_engine_chk #(.NFRAMES(NFRAMES), .IDX_W(IDX_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .acc_valid   (acc_valid),
    .fill_valid  (fill_valid),
    .acc_fault   (acc_fault),
    .evict_done  (evict_done),
    .evict_frame (evict_frame),
    .step_idx    (step_idx),
    .busy        (busy)
);

// File: tb/clock_evict_engine_tb.sv
module clock_evict_engine_tb;
    localparam int N  = 16;
    localparam int IW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          acc_valid = 1'b0, acc_write = 1'b0, fill_valid = 1'b0, evict_req = 1'b0;
    logic [IW-1:0] acc_frame = '0, fill_frame = '0;
    logic          acc_fault, evict_done, evict_dirty;
    logic [IW-1:0] evict_frame;

    int n_checks = 0;
    int n_fails  = 0;

    // Behavioural reference model state.
    bit m_p[N];
    bit m_a[N];
    bit m_w[N];
    int m_hand;
    bit m_busy;
    bit m_fault, m_done, m_dirty;
    int m_vic;

    always #2 clk = ~clk;

    clock_evict_engine #(.NFRAMES(N)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .acc_valid(acc_valid), .acc_write(acc_write), .acc_frame(acc_frame),
        .acc_fault(acc_fault),
        .fill_valid(fill_valid), .fill_frame(fill_frame),
        .evict_req(evict_req), .evict_done(evict_done),
        .evict_frame(evict_frame), .evict_dirty(evict_dirty)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Model advance on each rising edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) begin
                m_p[i] = 0; m_a[i] = 0; m_w[i] = 0;
            end
            m_hand = 0; m_busy = 0; m_fault = 0; m_done = 0; m_dirty = 0; m_vic = 0;
        end else begin
            bit hit;
            int f;
            f = int'(acc_frame);
            hit = acc_valid && m_p[f];
            m_fault = acc_valid && !m_p[f];
            m_done = 0;
            if (m_busy) begin
                if (m_a[m_hand]) begin
                    m_a[m_hand] = 0;
                end else begin
                    m_done  = 1;
                    m_vic   = m_hand;
                    m_dirty = m_w[m_hand] || (hit && acc_write && f == m_hand);
                    m_p[m_hand] = 0;
                    m_busy  = 0;
                end
                m_hand = (m_hand + 1) % N;
            end else if (evict_req) begin
                m_busy = 1;
            end
            if (hit) begin
                m_a[f] = 1;
                if (acc_write) m_w[f] = 1;
            end
            if (fill_valid) begin
                m_p[fill_frame] = 1; m_a[fill_frame] = 1; m_w[fill_frame] = 0;
            end
        end
    end

    // Compare DUT outputs with the model every cycle, away from the edge.
    always @(negedge clk) begin
        if (rst_n) begin
            check("R4 fault", int'(acc_fault), int'(m_fault));
            check("R6 done", int'(evict_done), int'(m_done));
            if (m_done) begin
                check("R6 victim", int'(evict_frame), m_vic);
                check("R3 dirty", int'(evict_dirty), int'(m_dirty));
            end
        end
    end

    task automatic idle();
        acc_valid = 0; acc_write = 0; fill_valid = 0; evict_req = 0;
    endtask

    task automatic access(input int fr, input bit wr);
        acc_valid = 1; acc_write = wr; acc_frame = IW'(fr);
        @(negedge clk); idle();
    endtask

    task automatic fill(input int fr);
        fill_valid = 1; fill_frame = IW'(fr);
        @(negedge clk); idle();
    endtask

    task automatic evict(output int fr, output bit dy, output int lat);
        evict_req = 1;
        @(negedge clk); idle();
        lat = 1;
        while (!evict_done && lat < 4 * N) begin
            @(negedge clk); lat++;
        end
        fr = int'(evict_frame); dy = evict_dirty;
        @(negedge clk);
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        #(200000 * 4);
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        int fr, lat, h, dones;
        bit dy;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1: outputs quiet and frames non-resident after reset
        check("R1 done low", int'(evict_done), 0);
        check("R1 fault low", int'(acc_fault), 0);
        access(3, 0);
        check("R1 frame 3 not resident -> fault", int'(acc_fault), 1);
        @(negedge clk);
        check("R4 fault lasts one cycle", int'(acc_fault), 0);

        for (int i = 0; i < N; i++) fill(i);
        evict(fr, dy, lat);
        check("R6 all referenced -> victim 0", fr, 0);
        check("R7 longest sweep latency", lat, N + 2);
        check("R3 clean victim", int'(dy), 0);

        access(1, 1);
        access(2, 0);
        evict(fr, dy, lat);
        check("R2 referenced frames 1,2 skipped -> victim 3", fr, 3);
        check("R9 sweep began at frame 1", lat, 4);

        access(3, 0);
        check("R8 evicted frame faults", int'(acc_fault), 1);
        fill(3);
        access(3, 0);
        check("R5 reloaded frame resident", int'(acc_fault), 0);

        evict(fr, dy, lat);
        check("R9 next victim follows previous", fr, 4);

        for (int k = 0; k < 20; k++) begin
            evict(fr, dy, lat);
            if (fr == 1) break;
        end
        check("R3 written frame reaches victim", fr, 1);
        check("R3 written frame dirty", int'(dy), 1);

        fill(1);
        for (int k = 0; k < 40; k++) begin
            evict(fr, dy, lat);
            if (fr == 1) break;
        end
        check("R5 reload clears modified bit", int'(dy), 0);

        for (int i = 0; i < N; i++) fill(i);
        h = m_hand;
        evict_req = 1;
        @(negedge clk);
        evict_req = 0; acc_valid = 1; acc_write = 0; acc_frame = IW'(h);
        @(negedge clk); idle();
        while (!evict_done) @(negedge clk);
        check("R10 same-cycle access keeps frame", int'(evict_frame), (h + 1) % N);
        @(negedge clk);

        // R11: a second request during the sweep is dropped
        for (int i = 0; i < N; i++) fill(i);
        evict_req = 1; @(negedge clk); idle();
        @(negedge clk);
        evict_req = 1; @(negedge clk); idle();
        dones = 0;
        for (int k = 0; k < 3 * N; k++) begin
            if (evict_done) dones++;
            @(negedge clk);
        end
        check("R11 request while busy ignored", dones, 1);

        // Random traffic; per-cycle comparison covers all requirements.
        for (int k = 0; k < 4000; k++) begin
            acc_valid  = ($urandom % 3) == 0;
            acc_write  = $urandom % 2;
            acc_frame  = IW'($urandom % N);
            fill_valid = ($urandom % 6) == 0;
            fill_frame = IW'($urandom % N);
            evict_req  = ($urandom % 5) == 0;
            @(negedge clk);
        end
        idle();
        repeat (2 * N + 4) @(negedge clk);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end
endmodule